// File: doc/BRIEF.md
# Constant-Off-Time Average-Current Gate Sequencer

This block drives the power switch of a step-down LED current regulator. It runs from a fast system clock and uses only digital inputs. A sense flag reports that the switch current has reached its reference, and a second flag reports that the current has crossed a hard limit. A dimming enable and a supply-good flag gate the whole activity. Counts supplied on input ports set the off-time, the blanking window and the restart delay.

Each switching period begins with the gate turned on. The block counts clock ticks until the sense flag is seen; this count is T1. The gate then stays on for a further (T1 + previous T1) / 2 ticks. Averaging the present and previous crossing times in this way damps period-doubling oscillation. A fixed off-time follows, and then the next period starts.

Several guards protect the switch. A blanking window at turn-on hides both flags from the controller. The on-time is capped so that it never exceeds 85 % of the period. A current-limit trip cuts the gate off and holds it off for a restart delay.

Top module: `avg_gate_seq`

## Requirements
- R1: T1 is the number of gate-high clock cycles up to and including the first cycle, outside blanking, in which `sense_i` is high at a rising clock edge. When no other rule ends the on-phase earlier, the gate stays high for exactly T1 + floor((T1 + Tprev) / 2) cycles, where Tprev is the T1 recorded in the previous period.
- R2: After every normal on-phase the gate stays low for exactly `off_len_i` cycles; a value of 0 counts as 1. The next on-phase then starts without any other condition.
- R3: While the gate-high cycle count is at most `blank_len_i`, the block ignores both `sense_i` and `ilim_i`. During that window neither flag ends the on-phase, records T1 or forces the gate low.
- R4: An on-phase never lasts longer than floor(max(`off_len_i`,1) × 17 / 3) cycles. That cap holds the on-count to no more than 85 % of the on-plus-off period.
- R5: A low `dim_en_i` forces `gate_o` low in the same cycle and returns the controller to idle. Switching restarts only once the enable is high again, and the restart begins a fresh on-phase.
- R6: A high `ilim_i` outside blanking forces `gate_o` low in the same cycle. `skip_o` is then high for exactly `skip_len_i` cycles (0 counts as 1) with the gate low. A fresh on-phase follows.
- R7: While `uv_ok_i` is low, the gate stays low and no switching period starts.
- R8: In the first on-phase after reset, after a dim-enable restart, or after a skip restart, Tprev is taken equal to T1, so the on-time is 2 × T1.
- R9: If an on-phase is ended by the cap of R4 without a sense crossing, the cap value is recorded as that period's T1. It serves as Tprev for the next period.
- R10: Reset clears `gate_o`, `skip_o` and `t1_o`. `t1_o` shows the most recently recorded T1 and changes only during an on-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_i | input | 1 | Switch current has reached the reference |
| ilim_i | input | 1 | Switch current has crossed the hard limit |
| dim_en_i | input | 1 | Dimming enable, high to switch |
| uv_ok_i | input | 1 | Supply above undervoltage threshold |
| off_len_i | input | CNT_W | Off-time in clock cycles |
| blank_len_i | input | BLANK_W | Blanking window in clock cycles |
| skip_len_i | input | CNT_W | Restart delay after a limit trip, in clock cycles |
| gate_o | output | 1 | Switch gate command |
| skip_o | output | 1 | High while the restart delay runs |
| t1_o | output | CNT_W | Last recorded reference-crossing time |

## Verification
The bench feeds the block a plant model that raises the sense flag a chosen number of gate-high cycles after turn-on. It then compares each on-pulse length with the averaging law over a sequence in which T1 changes. A design that dropped the previous crossing, or failed to clear it after reset, dimming or a skip, would give pulses a few cycles long or short. The bench also checks these corner cases:
- A cycle with no crossing, where the design must stop at the 283-cycle cap and then carry that cap into the next average.
- A sense flag raised inside blanking, which must give T1 = blank + 1 rather than the raw crossing.
- A limit pulse inside blanking, which must not trip the skip.
- A limit trip, whose skip length must match exactly.
- Gate behaviour when dimming drops mid-pulse.

// File: rtl/avg_gate_seq_pkg.sv
`timescale 1ns/1ps
package avg_gate_seq_pkg;

   // Switching phase of the sequencer.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2,
      PH_SKIP = 2'd3
   } phase_e;

endpackage

// File: rtl/avg_gate_seq_duty_cap.sv
`timescale 1ns/1ps
// Longest allowed on-count for a given off-count: off * NUM / DEN, saturated.
module avg_gate_seq_duty_cap #(
   parameter int CNT_W = 16,
   parameter int NUM   = 17,
   parameter int DEN   = 3
) (
   input  logic [CNT_W-1:0] off_len_i,
   output logic [CNT_W-1:0] on_max_o
);
   localparam int NUM_W    = $clog2(NUM + 1);
   localparam int PROD_W   = CNT_W + NUM_W;
   localparam bit DEN_POW2 = ((DEN & (DEN - 1)) == 0);
   localparam int DEN_SH   = $clog2(DEN);

   logic [CNT_W-1:0]  off_eff;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] quo;

   always_comb off_eff = (off_len_i == '0) ? CNT_W'(1) : off_len_i;
   assign prod = PROD_W'(off_eff) * PROD_W'(NUM);

   generate
      if (DEN_POW2) begin : g_shift
         assign quo = prod >> DEN_SH;
      end else begin : g_div
         assign quo = prod / PROD_W'(DEN);
      end
   endgenerate

   assign on_max_o = (quo > PROD_W'({CNT_W{1'b1}})) ? {CNT_W{1'b1}} : quo[CNT_W-1:0];
endmodule

// File: rtl/avg_gate_seq_ontime_law.sv
`timescale 1ns/1ps
// Averaging law: extension = (t1 + prev) / 2, end point = t1 + extension (saturated).
module avg_gate_seq_ontime_law #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] t1_i,
   input  logic [CNT_W-1:0] prev_i,
   input  logic             prev_ok_i,
   output logic [CNT_W-1:0] t2_o,
   output logic [CNT_W-1:0] end_o
);
   logic [CNT_W:0] pair_sum;
   logic [CNT_W:0] stretch;

   always_comb begin
      pair_sum = {1'b0, t1_i} + {1'b0, (prev_ok_i ? prev_i : t1_i)};
      t2_o     = CNT_W'(pair_sum >> 1);
      stretch  = {1'b0, t1_i} + {1'b0, t2_o};
      end_o    = stretch[CNT_W] ? {CNT_W{1'b1}} : stretch[CNT_W-1:0];
   end
endmodule

// File: rtl/avg_gate_seq_phase_timer.sv
`timescale 1ns/1ps
// Saturating phase-length counter; done on the last cycle of a limit-long phase.
module avg_gate_seq_phase_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   logic [CNT_W-1:0] ticks_q;
   logic [CNT_W-1:0] lim_eff;

   always_comb lim_eff = (limit_i == '0) ? CNT_W'(1) : limit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ticks_q <= '0;
      else if (clear_i)                     ticks_q <= '0;
      else if (run_i && (ticks_q != '1))    ticks_q <= ticks_q + 1'b1;
   end

   assign done_o = (({1'b0, ticks_q} + (CNT_W+1)'(1)) >= {1'b0, lim_eff});

   // R2 / R6: a running phase never outlasts its programmed length (limit held constant).
   a_r2_r6_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !clear_i) |-> (ticks_q < lim_eff));
endmodule

// File: rtl/avg_gate_seq.sv
`timescale 1ns/1ps
module avg_gate_seq
   import avg_gate_seq_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int BLANK_W  = 8,
   parameter int DUTY_NUM = 17,
   parameter int DUTY_DEN = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               sense_i,
   input  logic               ilim_i,
   input  logic               dim_en_i,
   input  logic               uv_ok_i,
   input  logic [CNT_W-1:0]   off_len_i,
   input  logic [BLANK_W-1:0] blank_len_i,
   input  logic [CNT_W-1:0]   skip_len_i,
   output logic               gate_o,
   output logic               skip_o,
   output logic [CNT_W-1:0]   t1_o
);
   // Elaboration-time parameter checks.
   generate
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("avg_gate_seq: CNT_W must be at least 4");
      end
      if (BLANK_W > CNT_W) begin : g_bad_blank_w
         $error("avg_gate_seq: BLANK_W must not exceed CNT_W");
      end
      if ((DUTY_DEN < 1) || (DUTY_NUM <= DUTY_DEN)) begin : g_bad_duty
         $error("avg_gate_seq: duty ratio NUM/DEN must exceed 1");
      end
   endgenerate

   phase_e           ph_q, ph_d;
   logic [CNT_W-1:0] on_cnt_q, goal_q, t1_q;
   logic [CNT_W-1:0] on_max, law_t2, law_end;
   logic             crossed_q, prev_ok_q;
   logic             run_ok, blanking, sense_hit, lim_hit, end_now, rec_en, enter_on;
   logic             off_done, skip_done;

   assign run_ok    = dim_en_i & uv_ok_i;
   assign blanking  = (on_cnt_q <= CNT_W'(blank_len_i));
   assign sense_hit = (ph_q == PH_ON) & ~crossed_q & ~blanking & sense_i;
   assign lim_hit   = (ph_q == PH_ON) & ~blanking & ilim_i;

   avg_gate_seq_duty_cap #(.CNT_W(CNT_W), .NUM(DUTY_NUM), .DEN(DUTY_DEN)) u_cap (
      .off_len_i (off_len_i),
      .on_max_o  (on_max)
   );

   avg_gate_seq_ontime_law #(.CNT_W(CNT_W)) u_law (
      .t1_i      (on_cnt_q),
      .prev_i    (t1_q),
      .prev_ok_i (prev_ok_q),
      .t2_o      (law_t2),
      .end_o     (law_end)
   );

   avg_gate_seq_phase_timer #(.CNT_W(CNT_W)) u_off_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i ((ph_d == PH_OFF) && (ph_q != PH_OFF)),
      .run_i   (ph_q == PH_OFF),
      .limit_i (off_len_i),
      .done_o  (off_done)
   );

   avg_gate_seq_phase_timer #(.CNT_W(CNT_W)) u_skip_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i ((ph_d == PH_SKIP) && (ph_q != PH_SKIP)),
      .run_i   (ph_q == PH_SKIP),
      .limit_i (skip_len_i),
      .done_o  (skip_done)
   );

   // The extension is consumed only through the end point; keep it visible for checks.
   logic t2_nonzero;
   assign t2_nonzero = |law_t2;

   assign end_now = (on_cnt_q >= on_max)
                  | (crossed_q & (on_cnt_q >= goal_q))
                  | (sense_hit & (on_cnt_q >= law_end));

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (run_ok)    ph_d = PH_ON;
         PH_ON:   if (lim_hit)   ph_d = PH_SKIP;
                  else if (end_now) ph_d = PH_OFF;
         PH_OFF:  if (off_done)  ph_d = PH_ON;
         PH_SKIP: if (skip_done) ph_d = PH_ON;
         default: ph_d = PH_IDLE;
      endcase
      if (!run_ok) ph_d = PH_IDLE;
   end

   assign enter_on = (ph_d == PH_ON) && (ph_q != PH_ON);
   assign rec_en   = (ph_q == PH_ON) && run_ok && !lim_hit
                   && (sense_hit || (end_now && !crossed_q));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q      <= PH_IDLE;
         on_cnt_q  <= '0;
         crossed_q <= 1'b0;
         goal_q    <= '0;
         t1_q      <= '0;
         prev_ok_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (enter_on)                                 on_cnt_q <= CNT_W'(1);
         else if ((ph_q == PH_ON) && (on_cnt_q != '1)) on_cnt_q <= on_cnt_q + 1'b1;
         if (enter_on)       crossed_q <= 1'b0;
         else if (sense_hit) crossed_q <= 1'b1;
         if (sense_hit) goal_q <= law_end;
         if (rec_en)    t1_q   <= on_cnt_q;
         if ((ph_d == PH_IDLE) || (ph_d == PH_SKIP)) prev_ok_q <= 1'b0;
         else if (rec_en)                            prev_ok_q <= 1'b1;
      end
   end

   assign gate_o = (ph_q == PH_ON) & run_ok & ~(ilim_i & ~blanking);
   assign skip_o = (ph_q == PH_SKIP);
   assign t1_o   = t1_q;

   // R5: a low dim enable always leaves the controller idle on the next cycle.
   a_r5_dim_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dim_en_i |=> (ph_q == PH_IDLE));
   // R7: a supply fault keeps the gate low on the following cycle.
   a_r7_uv_blocks_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !uv_ok_i |=> !gate_o);
   // R4: the on-count stays within the duty cap.
   a_r4_on_within_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_ON) |-> (on_cnt_q <= on_max));
   // R6: a skip only begins after a current-limit flag.
   a_r6_skip_from_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(skip_o) |-> $past(ilim_i));
   // R1: once crossed, the on-phase holds until the averaged end point.
   a_r1_hold_until_goal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ph_q == PH_ON) && crossed_q && (on_cnt_q < goal_q) && (on_cnt_q < on_max)
       && run_ok && !ilim_i) |=> (ph_q == PH_ON));
   // R1: the extension after a crossing is never zero.
   a_r1_extension_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sense_hit |-> t2_nonzero);
   // R3: blanking keeps the on-phase alive regardless of the flags.
   a_r3_blank_keeps_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ph_q == PH_ON) && blanking && run_ok && (on_cnt_q < on_max)) |=> (ph_q == PH_ON));
   // R10: the reported T1 changes only while the gate phase is active.
   a_r10_t1_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q != PH_ON) |=> $stable(t1_o));
endmodule

// File: tb/avg_gate_seq_bench.sv
`timescale 1ns/1ps
module avg_gate_seq_bench;
   localparam int W      = 16;
   localparam int BW     = 8;
   localparam int OFFN   = 50;
   localparam int BLANKN = 40;
   localparam int SKIPN  = 100;
   localparam int CAPN   = (OFFN * 17) / 3;   // 283

   logic clk = 1'b0, rst_n = 1'b0;
   logic sense = 1'b0, ilim = 1'b0, dim_en = 1'b0, uv_ok = 1'b0;
   logic [W-1:0]  off_len   = W'(OFFN);
   logic [W-1:0]  skip_len  = W'(SKIPN);
   logic [BW-1:0] blank_len = BW'(BLANKN);
   logic          gate, skip;
   logic [W-1:0]  t1;

   int n_chk = 0, n_err = 0;
   int thr = 100000, lim_lo = 100000, lim_hi = 0;
   int hicnt = 0, pops = 0, last_gap = 0;
   bit mon_en = 1'b0, done = 1'b0;

   int    q_len[$];
   int    q_t1[$];
   string q_tag[$];

   always #2 clk = ~clk;

   avg_gate_seq #(.CNT_W(W), .BLANK_W(BW)) u_avg_gate_seq (
      .clk_i(clk), .rst_ni(rst_n), .sense_i(sense), .ilim_i(ilim),
      .dim_en_i(dim_en), .uv_ok_i(uv_ok), .off_len_i(off_len),
      .blank_len_i(blank_len), .skip_len_i(skip_len),
      .gate_o(gate), .skip_o(skip), .t1_o(t1)
   );

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // Plant: sense after thr gate-high cycles, limit flag in a chosen window.
   initial forever begin
      @(negedge clk);
      if (gate) hicnt++; else hicnt = 0;
      sense = gate && (hicnt >= thr);
      ilim  = gate && (hicnt >= lim_lo) && (hicnt <= lim_hi);
   end

   // Monitor: measures pulses and gaps, pops the scoreboard on each falling gate.
   initial begin : mon
      bit prev_g;
      int len, gap, e_len, e_t1;
      string e_tag;
      prev_g = 1'b0; len = 0; gap = 0;
      forever begin
         @(negedge clk); #1;
         if (gate) begin
            if (!prev_g) begin last_gap = gap; len = 1; end
            else len++;
            gap = 0;
         end else begin
            gap++;
            if (prev_g) begin
               if (mon_en && (q_len.size() > 0)) begin
                  e_len = q_len.pop_front();
                  e_t1  = q_t1.pop_front();
                  e_tag = q_tag.pop_front();
                  check(e_tag, "on-time", len, e_len);
                  check(e_tag, "t1", int'(t1), e_t1);
               end
               pops++;
            end
         end
         prev_g = gate;
      end
   end

   task automatic expect_pulse(int th, int on_len, int t1v, string tag);
      int p0;
      thr = th;
      q_len.push_back(on_len); q_t1.push_back(t1v); q_tag.push_back(tag);
      p0 = pops;
      while (pops == p0) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic gate_low_for(int n, string tag);
      int seen;
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         if (gate) seen++;
      end
      check(tag, "gate-high samples", seen, 0);
   endtask

   initial begin
      #800000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
   end

   initial begin
      int n, hi;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      check("R10", "gate after reset", int'(gate), 0);
      check("R10", "skip after reset", int'(skip), 0);
      check("R10", "t1 after reset", int'(t1), 0);

      // R7: enable high but supply not ok: no switching.
      @(posedge clk); #1 dim_en = 1'b1;
      gate_low_for(20, "R7");

      @(posedge clk); #1 mon_en = 1'b1; thr = 60; uv_ok = 1'b1;
      expect_pulse(60, 120, 60, "R8 first period");
      expect_pulse(80, 150, 80, "R1 rising T1");
      expect_pulse(80, 160, 80, "R1 steady T1");
      check("R2", "off gap", last_gap, OFFN);
      expect_pulse(100000, CAPN, CAPN, "R4 R9 cap with no crossing");
      check("R2", "off gap after cap", last_gap, OFFN);
      expect_pulse(60, 231, 60, "R9 cap used as previous");
      expect_pulse(20, 91, 41, "R3 sense inside blanking");
      lim_lo = 10; lim_hi = 14;
      expect_pulse(60, 110, 60, "R3 limit inside blanking");
      check("R3", "skip after blanked limit", int'(skip), 0);

      // R6: limit trip after blanking.
      mon_en = 1'b0; thr = 60; lim_lo = 50; lim_hi = 53;
      do begin @(negedge clk); #1; end while (!ilim);
      check("R6", "gate with limit high", int'(gate), 0);
      lim_lo = 100000;
      do begin @(negedge clk); #1; end while (!skip);
      n = 0; hi = 0;
      while (skip) begin
         n++;
         if (gate) hi++;
         @(negedge clk); #1;
      end
      check("R6", "skip length", n, SKIPN);
      check("R6", "gate high during skip", hi, 0);
      mon_en = 1'b1;
      expect_pulse(70, 140, 70, "R6 R8 restart after skip");

      // R5: dim low mid-pulse.
      mon_en = 1'b0; thr = 100000;
      do begin @(negedge clk); #1; end while (!gate);
      repeat (30) @(posedge clk);
      #1 dim_en = 1'b0;
      #0.5 check("R5", "gate right after dim low", int'(gate), 0);
      gate_low_for(40, "R5");
      @(posedge clk); #1 mon_en = 1'b1; thr = 60; dim_en = 1'b1;
      expect_pulse(60, 120, 60, "R5 R8 fresh start after dim");

      // R7: supply fault while off.
      mon_en = 1'b0; uv_ok = 1'b0;
      gate_low_for(60, "R7");
      check("R10", "t1 held while idle", int'(t1), 60);
      report();
   end
endmodule